// File: doc/BRIEF.md
# Audio Control Register Slave on a Two-Wire Bus

This block is the control port of an audio processor. It listens on a two-wire serial bus (clock line SCL, data line SDA), responds to one fixed 7-bit device address, and keeps ten 8-bit control registers. A write transfer has three parts: the address byte, a subaddress byte and any number of data bytes. The subaddress byte selects a register and can turn on automatic advance of the register pointer. The register contents are always visible as one flat parallel output, with register *i* at bits `[8*i+7 : 8*i]`.

A read transfer returns a status byte built from four live status inputs. The block samples that byte again at the end of every acknowledge clock, so a master that keeps acknowledging sees fresh status values.

Both bus lines are synchronised to a much faster system clock. The slave drives SDA only as an open-drain pull-down enable.

Top module: `audio_ctl_i2c`

## Requirements
- R1: After reset, `sda_oe` is 0 and the registers hold these values (index: value): 0: 0x40, 1: 0x0E, 2: 0xFF, 3: 0xF7, 4 to 7: 0x1E each, 8: 0x78, 9: 0x6E.
- R2: The slave acknowledges an address byte whose upper seven bits, sent MSB first, are 1000100. Bit 0 of that byte is 0 for write and 1 for read, so the write byte is 0x88 and the read byte is 0x89. Any other address is not acknowledged, and the bytes that follow it change no register.
- R3: In the subaddress byte, bits 3:0 give the register index and bit 4 enables automatic pointer advance. Bits 7:5 have no effect on which register is written.
- R4: With bit 4 set, the pointer steps by one after each data byte and wraps from 15 to 0. Bytes aimed at indices 10 to 15 are acknowledged and then discarded.
- R5: With bit 4 clear, every data byte after the subaddress overwrites the same register.
- R6: Once a START has been accepted, further START conditions are ignored until a STOP is seen. This holds even after an address that was not acknowledged.
- R7: A read returns the status byte MSB first. Bits 7:4 are 0, bit 3 is `st_stereo`, bit 2 is `st_soft_mute`, bit 1 is `st_zc_mute` and bit 0 is `st_pause_n`.
- R8: The status byte is sampled at the falling SCL edge that ends each acknowledge clock. After a master ACK, the slave sends a freshly sampled byte. After a master NACK, the slave releases SDA until the next STOP.
- R9: The slave changes `sda_oe` only while SCL is low.
- R10: The slave acknowledges the subaddress byte and every data byte of a write to its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| st_stereo | input | 1 | Stereo indication for the status byte |
| st_soft_mute | input | 1 | Soft mute active indication |
| st_zc_mute | input | 1 | Zero-cross mute active indication |
| st_pause_n | input | 1 | Pause indication, low active |
| regs_o | output | NREG*8 | Flat register contents, register i at [8*i+7:8*i] |

## Verification
The bench builds the block with its default parameters: ten registers behind a 4-bit index field and a two-stage line synchroniser. With these values the six unmapped indices 10 to 15 lie on the path of an advancing pointer. This lets one burst that starts at index 8 cover the last mapped registers, the dropped range and the wrap to register 0. The bus runs with a quarter bit period of 20 system clocks, which leaves the synchroniser latency well inside each SCL phase.

// File: rtl/acs_pkg.sv
package acs_pkg;

   localparam int SUB_IDX_W  = 4;
   localparam int SUB_AI_BIT = 4;
   localparam int BYTE_W     = 8;
   localparam int DEF_NREG   = 10;

   // power-on values, register 0 in the low byte
   localparam logic [DEF_NREG*BYTE_W-1:0] DEF_RST_VALS = {
      8'h6E,   // 9 stereo decoder
      8'h78,   // 8 mute: direct mute on, window 11, detector reset
      8'h1E,   // 7 speaker RR
      8'h1E,   // 6 speaker RF
      8'h1E,   // 5 speaker LR
      8'h1E,   // 4 speaker LF
      8'hF7,   // 3 bass / treble
      8'hFF,   // 2 volume
      8'h0E,   // 1 loudness
      8'h40    // 0 input selector
   };

   typedef enum logic [3:0] {
      BS_IDLE,
      BS_ADDR,
      BS_AACK,
      BS_SUB,
      BS_SACK,
      BS_WDAT,
      BS_WACK,
      BS_RDAT,
      BS_RACK,
      BS_HOLD
   } bus_st_e;

   function automatic logic [BYTE_W-1:0] pack_status(input logic stereo,
                                                     input logic smute,
                                                     input logic zmute,
                                                     input logic pause_n);
      return {4'b0000, stereo, smute, zmute, pause_n};
   endfunction

endpackage

// File: rtl/acs_line_sync.sv
module acs_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("acs_line_sync: STAGES must be at least 2");
   end

   // one extra stage keeps the previous synchronised value
   logic [STAGES:0] scl_pipe;
   logic [STAGES:0] sda_pipe;
   logic            scl_q;
   logic            sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
      end
   end

   assign scl_s = scl_pipe[STAGES-1];
   assign sda_s = sda_pipe[STAGES-1];
   assign scl_q = scl_pipe[STAGES];
   assign sda_q = sda_pipe[STAGES];

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/acs_bus_engine.sv
module acs_bus_engine
   import acs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] status_byte,
   output logic              sda_oe,
   output logic              busy,
   output logic              sub_load,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] rx_byte
);

   localparam int CNT_W = $clog2(BYTE_W) + 1;
   localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W);

   bus_st_e           state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] txreg;
   logic              rd_mode;
   logic              m_ack;

   assign rx_byte = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= BS_IDLE;
         busy     <= 1'b0;
         bit_cnt  <= '0;
         shreg    <= '0;
         txreg    <= '0;
         rd_mode  <= 1'b0;
         m_ack    <= 1'b0;
         sda_oe   <= 1'b0;
         sub_load <= 1'b0;
         wr_stb   <= 1'b0;
      end else begin
         sub_load <= 1'b0;
         wr_stb   <= 1'b0;
         if (stop_det) begin
            state  <= BS_IDLE;
            busy   <= 1'b0;
            sda_oe <= 1'b0;
         end else if (start_det && !busy) begin
            state   <= BS_ADDR;
            busy    <= 1'b1;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else begin
            unique case (state)
               BS_ADDR, BS_SUB, BS_WDAT: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == BYTE_END) begin
                     bit_cnt <= '0;
                     if (state == BS_ADDR) begin
                        if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                           sda_oe  <= 1'b1;
                           rd_mode <= shreg[0];
                           state   <= BS_AACK;
                        end else begin
                           state <= BS_HOLD;
                        end
                     end else if (state == BS_SUB) begin
                        sda_oe   <= 1'b1;
                        sub_load <= 1'b1;
                        state    <= BS_SACK;
                     end else begin
                        sda_oe <= 1'b1;
                        wr_stb <= 1'b1;
                        state  <= BS_WACK;
                     end
                  end
               end
               BS_AACK: begin
                  if (scl_fall) begin
                     if (rd_mode) begin
                        txreg   <= status_byte;
                        sda_oe  <= ~status_byte[BYTE_W-1];
                        bit_cnt <= '0;
                        state   <= BS_RDAT;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= BS_SUB;
                     end
                  end
               end
               BS_SACK, BS_WACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= BS_WDAT;
                  end
               end
               BS_RDAT: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bit_cnt == BYTE_END) begin
                        sda_oe <= 1'b0;
                        state  <= BS_RACK;
                     end else begin
                        txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~txreg[BYTE_W-2];
                     end
                  end
               end
               BS_RACK: begin
                  if (scl_rise) begin
                     m_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (m_ack) begin
                        txreg   <= status_byte;
                        sda_oe  <= ~status_byte[BYTE_W-1];
                        bit_cnt <= '0;
                        state   <= BS_RDAT;
                     end else begin
                        state <= BS_HOLD;
                     end
                  end
               end
               default: begin
                  // idle, or parked until a STOP
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/acs_reg_bank.sv
module acs_reg_bank
   import acs_pkg::*;
#(
   parameter int                       NREG     = DEF_NREG,
   parameter int                       PTR_W    = SUB_IDX_W,
   parameter logic [NREG*BYTE_W-1:0]   RST_VALS = DEF_RST_VALS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sub_load,
   input  logic [PTR_W-1:0]         sub_idx,
   input  logic                     sub_ai,
   input  logic                     wr_stb,
   input  logic [BYTE_W-1:0]        wr_data,
   output logic [PTR_W-1:0]         ptr,
   output logic                     ai_en,
   output logic [NREG*BYTE_W-1:0]   regs_o
);

   if (NREG < 1 || NREG > (1 << PTR_W)) begin : g_bad_nreg
      $error("acs_reg_bank: NREG must fit the index field");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         ai_en <= 1'b0;
      end else if (sub_load) begin
         ptr   <= sub_idx;
         ai_en <= sub_ai;
      end else if (wr_stb && ai_en) begin
         ptr <= ptr + 1'b1;   // wraps at the index field width
      end
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_o[i*BYTE_W +: BYTE_W] <= RST_VALS[i*BYTE_W +: BYTE_W];
         end else if (wr_stb && ptr == PTR_W'(i)) begin
            regs_o[i*BYTE_W +: BYTE_W] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/audio_ctl_i2c.sv
module audio_ctl_i2c
   import acs_pkg::*;
#(
   parameter int                      NREG        = DEF_NREG,
   parameter logic [6:0]              DEV_ADDR    = 7'b1000100,
   parameter int                      SYNC_STAGES = 2,
   parameter logic [NREG*BYTE_W-1:0]  RST_VALS    = DEF_RST_VALS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_oe,
   input  logic                    st_stereo,
   input  logic                    st_soft_mute,
   input  logic                    st_zc_mute,
   input  logic                    st_pause_n,
   output logic [NREG*BYTE_W-1:0]  regs_o
);

   localparam int PTR_W = SUB_IDX_W;

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              busy;
   logic              sub_load;
   logic              wr_stb;
   logic [BYTE_W-1:0] rx_byte;
   logic [BYTE_W-1:0] status_byte;
   logic [PTR_W-1:0]  ptr;
   logic              ai_en;

   assign status_byte = pack_status(st_stereo, st_soft_mute, st_zc_mute, st_pause_n);

   acs_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   acs_bus_engine #(
      .DEV_ADDR (DEV_ADDR)
   ) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .sda_s       (sda_s),
      .scl_rise    (scl_rise),
      .scl_fall    (scl_fall),
      .start_det   (start_det),
      .stop_det    (stop_det),
      .status_byte (status_byte),
      .sda_oe      (sda_oe),
      .busy        (busy),
      .sub_load    (sub_load),
      .wr_stb      (wr_stb),
      .rx_byte     (rx_byte)
   );

   acs_reg_bank #(
      .NREG     (NREG),
      .PTR_W    (PTR_W),
      .RST_VALS (RST_VALS)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sub_load (sub_load),
      .sub_idx  (rx_byte[PTR_W-1:0]),
      .sub_ai   (rx_byte[SUB_AI_BIT]),
      .wr_stb   (wr_stb),
      .wr_data  (rx_byte),
      .ptr      (ptr),
      .ai_en    (ai_en),
      .regs_o   (regs_o)
   );

endmodule

// File: rtl/acs_chk.sv
module acs_chk #(
   parameter int NREG  = 10,
   parameter int PTR_W = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                scl_s,
   input logic                sda_oe,
   input logic                start_det,
   input logic                stop_det,
   input logic                busy,
   input logic                wr_stb,
   input logic                ai_en,
   input logic [PTR_W-1:0]    ptr,
   input logic [NREG*8-1:0]   regs
);

   localparam logic [PTR_W:0] NREG_W = (PTR_W+1)'(NREG);

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe));   // R9

   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && !busy));   // R6

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && busy && !stop_det) |=> busy);   // R6

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && ai_en) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));   // R4

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !ai_en) |=> $stable(ptr));   // R5

   AST_DROP_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && ({1'b0, ptr} >= NREG_W)) |=> $stable(regs));   // R4

endmodule

bind audio_ctl_i2c acs_chk #(
   .NREG  (NREG),
   .PTR_W (PTR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .sda_oe    (sda_oe),
   .start_det (start_det),
   .stop_det  (stop_det),
   .busy      (busy),
   .wr_stb    (wr_stb),
   .ai_en     (ai_en),
   .ptr       (ptr),
   .regs      (regs_o)
);

// File: tb/audio_ctl_i2c_tb.sv
module audio_ctl_i2c_tb;

   localparam int NREG = 10;
   localparam int Q    = 20;   // system clocks per quarter bit

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic st_stereo = 1'b0;
   logic st_soft_mute = 1'b0;
   logic st_zc_mute = 1'b0;
   logic st_pause_n = 1'b1;
   logic [NREG*8-1:0] regs_o;
   wire  sda_bus = sda_m & ~sda_oe;

   int checks = 0;
   int fails  = 0;
   int oe_viol = 0;
   bit done = 1'b0;
   logic [7:0] model [NREG];

   always #2 clk = ~clk;

   audio_ctl_i2c u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl),
      .sda_i        (sda_bus),
      .sda_oe       (sda_oe),
      .st_stereo    (st_stereo),
      .st_soft_mute (st_soft_mute),
      .st_zc_mute   (st_zc_mute),
      .st_pause_n   (st_pause_n),
      .regs_o       (regs_o)
   );

   // {subaddress, data}: single writes without pointer advance
   localparam logic [15:0] VEC [6] = '{
      {8'h00, 8'h81}, {8'hE3, 8'h5A}, {8'h27, 8'hC3},
      {8'hC9, 8'h01}, {8'h04, 8'hFF}, {8'h61, 8'h00}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_regs(input string req);
      for (int i = 0; i < NREG; i++) chk(req, 32'(regs_o[i*8 +: 8]), 32'(model[i]));
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
   endtask

   task automatic bus_bit(input logic b);
      sda_m = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) bus_bit(b[i]);
      sda_m = 1'b1; qw(); scl = 1'b1; qw();
      ack = ~sda_bus;
      qw(); scl = 1'b0; qw();
   endtask

   task automatic rbyte(input logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qw(); scl = 1'b1; qw();
         b[i] = sda_bus;
         qw(); scl = 1'b0; qw();
      end
      bus_bit(~give_ack);
   endtask

   // R9 monitor: the slave's drive must not move while SCL is high
   logic scl_prev = 1'b1;
   logic oe_prev  = 1'b0;
   always @(posedge clk) begin
      #1;
      if (rst_n && scl && scl_prev && (sda_oe !== oe_prev)) oe_viol++;
      scl_prev = scl;
      oe_prev  = sda_oe;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic ack;
      logic [7:0] rb;
      model = '{8'h40, 8'h0E, 8'hFF, 8'hF7, 8'h1E, 8'h1E, 8'h1E, 8'h1E, 8'h78, 8'h6E};
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      // R1 reset state
      chk("R1 sda_oe", 32'(sda_oe), 0);
      chk_regs("R1");

      // R3 table of single writes
      for (int v = 0; v < 6; v++) begin
         bus_start();
         wbyte(8'h88, ack); chk("R2 addr ack", 32'(ack), 1);
         wbyte(VEC[v][15:8], ack); chk("R10 sub ack", 32'(ack), 1);
         wbyte(VEC[v][7:0], ack); chk("R10 data ack", 32'(ack), 1);
         bus_stop();
         model[VEC[v][11:8]] = VEC[v][7:0];
         chk_regs("R3");
      end

      // R4 advancing pointer across unmapped indices and wrap
      bus_start();
      wbyte(8'h88, ack);
      wbyte(8'h18, ack);
      for (int k = 0; k < 9; k++) begin
         wbyte(8'hA0 + 8'(k), ack);
         chk("R4 ack", 32'(ack), 1);
      end
      bus_stop();
      model[8] = 8'hA0; model[9] = 8'hA1; model[0] = 8'hA8;
      chk_regs("R4");

      // R5 repeated bytes without advance
      bus_start();
      wbyte(8'h88, ack);
      wbyte(8'h05, ack);
      wbyte(8'h11, ack); wbyte(8'h22, ack); wbyte(8'h33, ack);
      chk("R5 ack", 32'(ack), 1);
      bus_stop();
      model[5] = 8'h33;
      chk_regs("R5");

      // R2 foreign address, R6 START ignored before STOP
      bus_start();
      wbyte(8'h8A, ack); chk("R2 foreign nack", 32'(ack), 0);
      bus_start();
      wbyte(8'h88, ack); chk("R6 start ignored", 32'(ack), 0);
      wbyte(8'h02, ack);
      wbyte(8'h77, ack); chk("R6 no ack in hold", 32'(ack), 0);
      bus_stop();
      chk_regs("R6");
      bus_start();
      wbyte(8'h88, ack); chk("R6 after stop", 32'(ack), 1);
      wbyte(8'h02, ack);
      wbyte(8'h3C, ack);
      bus_stop();
      model[2] = 8'h3C;
      chk_regs("R6");

      // R7 / R8 status reads
      st_stereo = 1'b1; st_soft_mute = 1'b0; st_zc_mute = 1'b1; st_pause_n = 1'b0;
      bus_start();
      wbyte(8'h89, ack); chk("R7 read addr ack", 32'(ack), 1);
      rbyte(1'b1, rb); chk("R7 status", 32'(rb), 32'h0A);
      st_stereo = 1'b0; st_soft_mute = 1'b1; st_zc_mute = 1'b0; st_pause_n = 1'b1;
      rbyte(1'b1, rb); chk("R8 byte sampled at ack", 32'(rb), 32'h0A);
      rbyte(1'b0, rb); chk("R8 resampled", 32'(rb), 32'h05);
      chk("R8 released after nack", 32'(sda_oe), 0);
      bus_stop();
      chk_regs("R8");

      chk("R9 drive moves only with SCL low", 32'(oe_viol), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule